// File: doc/BRIEF.md
# Vector Element Reversal Unit

This block is one registered pipeline stage that reverses the order of elements inside fixed-size containers of a 128-bit vector. It accepts a source vector and a 32-bit instruction word. From the instruction it identifies one of three operations: reverse inside 64-bit containers, inside 32-bit containers, or inside 16-bit containers. The element size (byte, halfword or word) comes from a two-bit field. A width bit chooses between the full 128-bit vector and the lower 64 bits only.

Each result element is taken from the source element whose lane index differs only in the bits that pick a position inside the container. That is, the source lane is the destination lane XOR a mask set by the container and the element size. Size and container pairings that are not allocated raise an undefined flag and give zero data. A word that matches none of the three encodings raises a separate no-match flag. The source and destination register fields are passed through with the result, so a register file outside the block can use them.

Top module: `vrev_unit`

## Requirements
- R1: While `rst_n` is low and until the first accepted input, `out_valid`, `out_undef` and `out_nomatch` are 0, and `out_data`, `out_rn` and `out_rd` are zero.
- R2: `out_valid` is high in the cycle after a clock edge with `in_valid` high, and low in the cycle after an edge with `in_valid` low.
- R3: 64-bit-container form: bit 31 = 0, bits 29:24 = 0x0E, bits 21:10 = 0x802. Size 0 (bytes) sources lane i from lane i^7. Size 1 (halfwords) uses i^3. Size 2 (words) uses i^1. Size 3 is undefined.
- R4: 32-bit-container form: bit 31 = 0, bits 29:24 = 0x2E, bits 21:10 = 0x802. Size 0 uses lane i^3 and size 1 uses lane i^1. Sizes 2 and 3 are undefined.
- R5: 16-bit-container form: bit 31 = 0, bits 29:24 = 0x0E, bits 21:10 = 0x806. Size 0 uses byte lane i^1. Sizes 1 to 3 are undefined.
- R6: Bit 30 = 1 processes all 128 bits. Bit 30 = 0 processes only bits 63:0 and drives result bits 127:64 to zero.
- R7: For an undefined pairing, `out_undef` = 1, `out_nomatch` = 0, `out_data` = 0, and `out_valid` still asserts one cycle later.
- R8: A word that matches none of the three encodings (including any word with bit 31 = 1) gives `out_nomatch` = 1, `out_undef` = 0 and `out_data` = 0.
- R9: Bits 9:5 appear on `out_rn` and bits 4:0 on `out_rd` one cycle after acceptance. Neither field changes `out_data`.
- R10: In a cycle with `in_valid` low, `out_data`, `out_undef`, `out_nomatch`, `out_rn` and `out_rd` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and vector are presented this cycle |
| in_insn | input | 32 | Instruction word |
| in_vec | input | VEC_W (128) | Source vector, byte lane 0 in bits 7:0 |
| out_valid | output | 1 | Registered result is new this cycle |
| out_data | output | VEC_W (128) | Reversed vector |
| out_undef | output | 1 | Recognised form with an unallocated size |
| out_nomatch | output | 1 | Word matches no reversal form |
| out_rn | output | 5 | Source register field, passed through |
| out_rd | output | 5 | Destination register field, passed through |

## Verification
The bench builds the unit with its default 128-bit vector width. At that width the whole decode space of interest is small enough to sweep: every form, every size code and both width settings, each with several data patterns. These include a pattern where each byte holds its own lane number, so any wrong lane shows up at once. Near-miss encodings show that the decode rejects them. Changing inputs while `in_valid` is low shows that the held result stays fixed.

// File: rtl/vrev_pkg.sv
package vrev_pkg;

    localparam int INSN_W = 32;
    localparam int REG_W  = 5;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_C64  = 2'd1,
        OP_C32  = 2'd2,
        OP_C16  = 2'd3
    } rev_op_e;

    typedef struct packed {
        rev_op_e          op;
        logic             full;
        logic [1:0]       esize;
        logic             undef;
        logic             nomatch;
        logic [REG_W-1:0] rn;
        logic [REG_W-1:0] rd;
    } rev_dec_t;

endpackage

// File: rtl/vrev_decode.sv
module vrev_decode
    import vrev_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output rev_dec_t          dec
);

    localparam logic [5:0]  GRP_LO  = 6'h0E;
    localparam logic [5:0]  GRP_HI  = 6'h2E;
    localparam logic [11:0] SUB_A   = 12'h802;
    localparam logic [11:0] SUB_B   = 12'h806;

    logic top_ok;
    assign top_ok = (insn[31] == 1'b0);

    always_comb begin
        dec       = '0;
        dec.full  = insn[30];
        dec.esize = insn[23:22];
        dec.rn    = insn[9:5];
        dec.rd    = insn[4:0];
        if (top_ok && insn[29:24] == GRP_LO && insn[21:10] == SUB_A)
            dec.op = OP_C64;
        else if (top_ok && insn[29:24] == GRP_LO && insn[21:10] == SUB_B)
            dec.op = OP_C16;
        else if (top_ok && insn[29:24] == GRP_HI && insn[21:10] == SUB_A)
            dec.op = OP_C32;
        else
            dec.op = OP_NONE;

        dec.nomatch = (dec.op == OP_NONE);
        unique case (dec.op)
            OP_C64:  dec.undef = (dec.esize == 2'd3);
            OP_C32:  dec.undef = dec.esize[1];
            OP_C16:  dec.undef = (dec.esize != 2'd0);
            default: dec.undef = 1'b0;
        endcase
    end

endmodule

// File: rtl/vrev_permute.sv
module vrev_permute
    import vrev_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] vec,
    input  rev_op_e          op,
    input  logic [1:0]       esize,
    input  logic             full,
    output logic [VEC_W-1:0] res
);

    localparam int NBYTES = VEC_W / 8;
    localparam int HALF_B = NBYTES / 2;
    localparam int IDX_W  = $clog2(NBYTES);

    logic [2:0] cont_mask;
    logic [2:0] elem_mask;
    logic [2:0] swap_mask;

    always_comb begin
        unique case (op)
            OP_C64:  cont_mask = 3'd7;
            OP_C32:  cont_mask = 3'd3;
            OP_C16:  cont_mask = 3'd1;
            default: cont_mask = 3'd0;
        endcase
        unique case (esize)
            2'd0:    elem_mask = 3'd0;
            2'd1:    elem_mask = 3'd1;
            2'd2:    elem_mask = 3'd3;
            default: elem_mask = 3'd7;
        endcase
        swap_mask = cont_mask ^ elem_mask;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [IDX_W-1:0] src_idx;
        logic [7:0]       picked;
        assign src_idx = IDX_W'(b) ^ IDX_W'(swap_mask);
        assign picked  = vec[src_idx*8 +: 8];
        if (b >= HALF_B) begin : g_upper
            assign res[b*8 +: 8] = full ? picked : 8'h00;
        end else begin : g_lower
            assign res[b*8 +: 8] = picked;
        end
    end

endmodule

// File: rtl/vrev_unit.sv
module vrev_unit
    import vrev_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_insn,
    input  logic [VEC_W-1:0]  in_vec,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_data,
    output logic              out_undef,
    output logic              out_nomatch,
    output logic [4:0]        out_rn,
    output logic [4:0]        out_rd
);

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] data;
        logic             undef;
        logic             nomatch;
        logic [REG_W-1:0] rn;
        logic [REG_W-1:0] rd;
    } stage_t;

    rev_dec_t         dec;
    logic [VEC_W-1:0] perm;
    stage_t           stage_d;
    stage_t           stage_q;

    vrev_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    vrev_permute #(.VEC_W(VEC_W)) u_perm (
        .vec   (in_vec),
        .op    (dec.op),
        .esize (dec.esize),
        .full  (dec.full),
        .res   (perm)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.undef   = dec.undef;
            stage_d.nomatch = dec.nomatch;
            stage_d.rn      = dec.rn;
            stage_d.rd      = dec.rd;
            stage_d.data    = (dec.undef || dec.nomatch) ? '0 : perm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid   = stage_q.valid;
    assign out_data    = stage_q.data;
    assign out_undef   = stage_q.undef;
    assign out_nomatch = stage_q.nomatch;
    assign out_rn      = stage_q.rn;
    assign out_rd      = stage_q.rd;

endmodule

// File: rtl/vrev_unit_chk.sv
module vrev_unit_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      in_insn,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_data,
    input logic             out_undef,
    input logic             out_nomatch,
    input logic [4:0]       out_rn,
    input logic [4:0]       out_rd
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r6_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_insn[30]) |=> (out_data[VEC_W-1:VEC_W/2] == '0));

    a_r7_flag_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_undef || out_nomatch) |-> (out_data == '0));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_undef && out_nomatch));

    a_r8_top_bit_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_insn[31]) |=> out_nomatch);

    a_r9_fields_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_rd == $past(in_insn[4:0]) && out_rn == $past(in_insn[9:5])));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_undef) && $stable(out_nomatch)
                       && $stable(out_rd) && $stable(out_rn)));

endmodule

bind vrev_unit vrev_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_insn     (in_insn),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_undef   (out_undef),
    .out_nomatch (out_nomatch),
    .out_rn      (out_rn),
    .out_rd      (out_rd)
);

// File: tb/vrev_unit_test.sv
module vrev_unit_test;

    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   in_insn = '0;
    logic [VW-1:0] in_vec = '0;
    logic          out_valid;
    logic [VW-1:0] out_data;
    logic          out_undef;
    logic          out_nomatch;
    logic [4:0]    out_rn;
    logic [4:0]    out_rd;

    int errors = 0;
    int checks = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    vrev_unit #(.VEC_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .in_vec(in_vec), .out_valid(out_valid), .out_data(out_data),
        .out_undef(out_undef), .out_nomatch(out_nomatch),
        .out_rn(out_rn), .out_rd(out_rd)
    );

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // form: 0 = 64-bit container, 1 = 32-bit, 2 = 16-bit
    function automatic logic [31:0] make_insn(input int form, input logic q,
                                              input logic [1:0] sz,
                                              input logic [4:0] rn, input logic [4:0] rd);
        logic [5:0]  grp;
        logic [11:0] sub;
        grp = (form == 1) ? 6'h2E : 6'h0E;
        sub = (form == 2) ? 12'h806 : 12'h802;
        return {1'b0, q, grp, sz, sub, rn, rd};
    endfunction

    function automatic logic expect_undef(input int form, input logic [1:0] sz);
        if (form == 0) return sz == 2'd3;
        if (form == 1) return sz >= 2'd2;
        return sz != 2'd0;
    endfunction

    function automatic logic [VW-1:0] expect_data(input int form, input logic q,
                                                  input logic [1:0] sz,
                                                  input logic [VW-1:0] v);
        logic [VW-1:0] r;
        int cb;
        int eb;
        int m;
        int lim;
        r = '0;
        if (expect_undef(form, sz)) return r;
        cb  = (form == 0) ? 8 : (form == 1) ? 4 : 2;
        eb  = 1 << sz;
        m   = (cb - 1) ^ (eb - 1);
        lim = q ? VW / 8 : VW / 16;
        for (int b = 0; b < lim; b++)
            r[b*8 +: 8] = v[(b ^ m)*8 +: 8];
        return r;
    endfunction

    task automatic run(input string req, input logic [31:0] insn, input logic [VW-1:0] vec,
                       input logic [VW-1:0] edata, input logic eund, input logic enm);
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = insn;
        in_vec   = vec;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R2 valid"}, VW'(out_valid), VW'(1));
        chk({req, " data"}, out_data, edata);
        chk({req, " R7 undef"}, VW'(out_undef), VW'(eund));
        chk({req, " R8 nomatch"}, VW'(out_nomatch), VW'(enm));
        chk({req, " R9 rd"}, VW'(out_rd), VW'(insn[4:0]));
        chk({req, " R9 rn"}, VW'(out_rn), VW'(insn[9:5]));
        // R10: inputs change while idle, result must hold
        in_insn = ~insn;
        in_vec  = ~vec;
        @(negedge clk);
        chk({req, " R10 hold data"}, out_data, edata);
        chk({req, " R10 hold undef"}, VW'(out_undef), VW'(eund));
        chk({req, " R2 idle valid"}, VW'(out_valid), VW'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [VW-1:0] ramp;
        logic [VW-1:0] v;
        logic [31:0]   w;
        string         tag;
        for (int b = 0; b < VW / 8; b++) ramp[b*8 +: 8] = 8'(b);

        repeat (3) @(negedge clk);
        chk("R1 reset valid", VW'(out_valid), VW'(0));
        chk("R1 reset data", out_data, '0);
        chk("R1 reset flags", VW'({out_undef, out_nomatch}), VW'(0));
        chk("R1 reset regs", VW'({out_rn, out_rd}), VW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", VW'({out_valid, out_undef, out_nomatch}), VW'(0));

        // R3 R4 R5 R6: every form, size and width with several patterns
        for (int f = 0; f < 3; f++) begin
            tag = (f == 0) ? "R3" : (f == 1) ? "R4" : "R5";
            for (int s = 0; s < 4; s++) begin
                for (int q = 0; q < 2; q++) begin
                    for (int p = 0; p < 4; p++) begin
                        if (p == 0) v = ramp;
                        else begin
                            for (int k = 0; k < 4; k++) begin
                                seed = next_rand(seed);
                                v[k*32 +: 32] = seed;
                            end
                        end
                        w = make_insn(f, q[0], s[1:0], 5'(p * 7 + s), 5'(31 - p - f));
                        run({tag, q ? " full" : " R6 half"}, w, v,
                            expect_data(f, q[0], s[1:0], v),
                            expect_undef(f, s[1:0]), 1'b0);
                    end
                end
            end
        end

        // R9: register fields do not change the data
        run("R9 rn=0", make_insn(0, 1'b1, 2'd0, 5'd0, 5'd31), ramp,
            expect_data(0, 1'b1, 2'd0, ramp), 1'b0, 1'b0);
        run("R9 rn=31", make_insn(0, 1'b1, 2'd0, 5'd31, 5'd0), ramp,
            expect_data(0, 1'b1, 2'd0, ramp), 1'b0, 1'b0);

        // R8: near-miss encodings
        w = make_insn(0, 1'b1, 2'd0, 5'd3, 5'd4);
        run("R8 bit31 set", w | 32'h8000_0000, ramp, '0, 1'b0, 1'b1);
        w = make_insn(1, 1'b1, 2'd0, 5'd3, 5'd4);
        run("R8 grp2E sub806", (w & ~32'h003F_FC00) | (32'h806 << 10), ramp, '0, 1'b0, 1'b1);
        w = make_insn(0, 1'b1, 2'd1, 5'd3, 5'd4);
        run("R8 sub803", (w & ~32'h003F_FC00) | (32'h803 << 10), ramp, '0, 1'b0, 1'b1);
        run("R8 grp1E", (w & ~32'h3F00_0000) | 32'h1E00_0000, ramp, '0, 1'b0, 1'b1);
        run("R8 all zero", 32'h0, ramp, '0, 1'b0, 1'b1);

        // R2: back-to-back acceptance
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = make_insn(2, 1'b1, 2'd0, 5'd1, 5'd2);
        in_vec   = ramp;
        @(negedge clk);
        in_insn  = make_insn(0, 1'b0, 2'd2, 5'd1, 5'd9);
        chk("R2 back-to-back first", out_data, expect_data(2, 1'b1, 2'd0, ramp));
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 back-to-back valid", VW'(out_valid), VW'(1));
        chk("R2 back-to-back second", out_data, expect_data(0, 1'b0, 2'd2, ramp));
        @(negedge clk);
        chk("R2 drop valid", VW'(out_valid), VW'(0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule